// File: doc/BRIEF.md
# Ethernet Statistics Counter Bank

This block keeps the receive or transmit statistics of one Ethernet port. At the end of each frame the MAC presents a one-cycle status record: the frame length in bytes (preamble, SFD and jam already excluded), a VLAN-tag flag, an FCS-good flag and an abort cause code. The bank updates six frame-size bin counters, a good-VLAN-frame counter, a byte counter and an oversize-frame counter. All counters are 32 bits wide by default and wrap to zero. A wrap sets that counter's bit in a carry register, and software clears the bit by writing 1 to it.

Software reaches the bank through a single-cycle register port. Read data is combinational from the current state. Writing a counter address loads that counter. The carry register is write-1-to-clear. A control register holds an auto-zero mode bit and a self-clearing clear-all command bit. With auto-zero set, every host read of a counter also zeroes it.

Register map (word addresses on `reg_addr_i`):

| Address | Register |
|---|---|
| 0 | bin, length ≤ 64 |
| 1 | bin, 65..127 |
| 2 | bin, 128..255 |
| 3 | bin, 256..511 |
| 4 | bin, 512..1023 |
| 5 | bin, ≥ 1024 |
| 6 | good VLAN frames |
| 7 | bytes |
| 8 | oversize frames |
| 9 | carry register; bit i belongs to the counter at address i |
| 10 | control: bit 1 auto-zero, bit 0 clear-all |

Top module: `stats_bank`

## Requirements
- R1: After reset, every counter, the carry register and the auto-zero bit are zero, so all of addresses 0 to 10 read 0.
- R2: When `stat_valid_i` is high and `stat_abort_i` is 0, exactly one bin counter (addresses 0 to 5) increments by 1. The counter is chosen by length: ≤64, 65–127, 128–255, 256–511, 512–1023, ≥1024. The new value is visible from the next clock edge.
- R3: A record with a nonzero `stat_abort_i` code changes none of the bin counters and not the good-VLAN counter. Every nonzero code names an abort cause (retry limit, late collision, underrun, bus error, FIFO data error, truncation, excessive deferral) and all are treated alike.
- R4: The good-VLAN counter (address 6) increments only for a record that is VLAN tagged, has a good FCS and is not aborted.
- R5: The byte counter (address 7) adds `stat_len_i` for every valid record, aborted or not.
- R6: The oversize counter (address 8) increments for a record with a good FCS whose length exceeds 1518 when untagged, or 1522 when tagged.
- R7: A counter that passes 2^32−1 keeps the result modulo 2^32 and sets its carry bit at the same clock edge.
- R8: A write to address 9 clears each carry bit written as 1 and leaves each bit written as 0 unchanged. A wrap in the same cycle as a clear keeps the bit set.
- R9: Writing address 10 with bit 0 set zeroes every counter and the carry register at that edge. This overrides any update in the same cycle. Bit 0 always reads back as 0.
- R10: With auto-zero (address 10 bit 1) set, a read of a counter returns its value and zeroes it at that edge. If a statistics update hits the same counter in that cycle, the counter ends holding only the new increment. With auto-zero clear, a read leaves the counter unchanged.
- R11: A host write to a counter address loads the written value. Any increment in the same cycle is added on top of it, and a carry out of that sum sets the carry bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| stat_valid_i | input | 1 | Frame status record valid, one cycle per frame |
| stat_len_i | input | 16 | Frame length in bytes, excluding preamble, SFD and jam |
| stat_vlan_i | input | 1 | Frame carried a VLAN tag |
| stat_fcs_ok_i | input | 1 | Frame check sequence was correct |
| stat_abort_i | input | 3 | Abort cause, 0 = not aborted |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (drives auto-zero) |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from the address |

## Verification
A status record, a counter load, a carry clear or a clear-all is sampled at one rising edge. Its effect is visible on `reg_rdata_o` from that edge onward, with no further pipeline stage. Read data for an address is due in the same cycle the address is driven. The auto-zero of that read lands at the edge that closes the read cycle. The bench drives every stimulus just after a falling edge, samples read data one time unit later, and lets exactly one rising edge pass per operation. Each result is therefore read in the first cycle after the edge that produced it. Same-cycle collisions (update with clear, with wrap, with clear-on-read) are driven in a single cycle so that their priority is observed directly.

// File: rtl/stats_pkg.sv
package stats_pkg;
  localparam int NUM_BINS  = 6;
  localparam int NUM_CNT   = 9;
  localparam int ADDR_W    = 4;
  localparam int IDX_VLAN  = 6;
  localparam int IDX_BYTES = 7;
  localparam int IDX_OVER  = 8;
  localparam logic [ADDR_W-1:0] ADDR_CARRY = 4'd9;
  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 4'd10;
  localparam int CTRL_CLR_BIT = 0;
  localparam int CTRL_AZ_BIT  = 1;

  // upper length bound of bin i (last bin is open)
  function automatic int unsigned bin_top(input int i);
    return (i == 0) ? 64 : ((64 << i) - 1);
  endfunction
endpackage

// File: rtl/stats_classify.sv
module stats_classify
  import stats_pkg::*;
#(
  parameter int CNT_W        = 32,
  parameter int LEN_W        = 16,
  parameter int ABORT_W      = 3,
  parameter int MAX_UNTAGGED = 1518,
  parameter int VLAN_EXTRA   = 4
) (
  input  logic                              valid_i,
  input  logic [LEN_W-1:0]                  len_i,
  input  logic                              vlan_i,
  input  logic                              fcs_ok_i,
  input  logic [ABORT_W-1:0]                abort_i,
  output logic [NUM_CNT-1:0][CNT_W-1:0]     inc_o
);
  localparam logic [LEN_W-1:0] LIM_PLAIN = LEN_W'(MAX_UNTAGGED);
  localparam logic [LEN_W-1:0] LIM_TAG   = LEN_W'(MAX_UNTAGGED + VLAN_EXTRA);

  logic               clean;
  logic [NUM_BINS-1:0] in_bin;
  logic [LEN_W-1:0]   over_lim;
  logic               vlan_hit, over_hit;

  assign clean = valid_i && (abort_i == '0);

  for (genvar i = 0; i < NUM_BINS; i++) begin : g_bin
    if (i == 0) begin : g_first
      assign in_bin[i] = len_i <= LEN_W'(bin_top(i));
    end else if (i == NUM_BINS - 1) begin : g_last
      assign in_bin[i] = len_i > LEN_W'(bin_top(i - 1));
    end else begin : g_mid
      assign in_bin[i] = (len_i > LEN_W'(bin_top(i - 1))) &&
                         (len_i <= LEN_W'(bin_top(i)));
    end
    assign inc_o[i] = CNT_W'(clean && in_bin[i]);
  end

  assign over_lim = vlan_i ? LIM_TAG : LIM_PLAIN;
  assign vlan_hit = clean && vlan_i && fcs_ok_i;
  assign over_hit = valid_i && fcs_ok_i && (len_i > over_lim);

  assign inc_o[IDX_VLAN]  = CNT_W'(vlan_hit);
  assign inc_o[IDX_BYTES] = valid_i ? CNT_W'(len_i) : '0;
  assign inc_o[IDX_OVER]  = CNT_W'(over_hit);
endmodule

// File: rtl/stats_counter.sv
module stats_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             zero_i,
  input  logic [CNT_W-1:0] inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] base;
  logic [CNT_W:0]   sum;

  // load wins over clear-on-read; increment always lands on top
  assign base   = load_i ? load_val_i : (zero_i ? '0 : cnt_o);
  assign sum    = {1'b0, base} + {1'b0, inc_i};
  assign wrap_o = sum[CNT_W] && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else            cnt_o <= sum[CNT_W-1:0];
  end
endmodule

// File: rtl/stats_carry.sv
module stats_carry #(
  parameter int N = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         w1c_i,
  input  logic [N-1:0] mask_i,
  input  logic [N-1:0] set_i,
  output logic [N-1:0] carry_o
);
  logic [N-1:0] keep;

  assign keep = w1c_i ? ~mask_i : '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    carry_o <= '0;
    else if (clr_i) carry_o <= '0;
    else            carry_o <= (carry_o & keep) | set_i;
  end
endmodule

// File: rtl/stats_bank.sv
module stats_bank
  import stats_pkg::*;
#(
  parameter int CNT_W        = 32,
  parameter int LEN_W        = 16,
  parameter int ABORT_W      = 3,
  parameter int MAX_UNTAGGED = 1518,
  parameter int VLAN_EXTRA   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               stat_valid_i,
  input  logic [LEN_W-1:0]   stat_len_i,
  input  logic               stat_vlan_i,
  input  logic               stat_fcs_ok_i,
  input  logic [ABORT_W-1:0] stat_abort_i,
  input  logic               reg_wr_i,
  input  logic               reg_rd_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [CNT_W-1:0]   reg_wdata_i,
  output logic [CNT_W-1:0]   reg_rdata_o
);
  logic [NUM_CNT-1:0][CNT_W-1:0] inc;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q;
  logic [NUM_CNT-1:0]            wrap;
  logic [NUM_CNT-1:0]            carry_q;
  logic                          az_q;
  logic                          ctrl_wr, clear_all, carry_wr;

  assign ctrl_wr   = reg_wr_i && (reg_addr_i == ADDR_CTRL);
  assign clear_all = ctrl_wr && reg_wdata_i[CTRL_CLR_BIT];
  assign carry_wr  = reg_wr_i && (reg_addr_i == ADDR_CARRY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      az_q <= 1'b0;
    else if (ctrl_wr) az_q <= reg_wdata_i[CTRL_AZ_BIT];
  end

  stats_classify #(
    .CNT_W(CNT_W), .LEN_W(LEN_W), .ABORT_W(ABORT_W),
    .MAX_UNTAGGED(MAX_UNTAGGED), .VLAN_EXTRA(VLAN_EXTRA)
  ) u_classify (
    .valid_i (stat_valid_i),
    .len_i   (stat_len_i),
    .vlan_i  (stat_vlan_i),
    .fcs_ok_i(stat_fcs_ok_i),
    .abort_i (stat_abort_i),
    .inc_o   (inc)
  );

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    logic hit;
    assign hit = reg_addr_i == ADDR_W'(i);
    stats_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (clear_all),
      .load_i    (reg_wr_i && hit),
      .load_val_i(reg_wdata_i),
      .zero_i    (reg_rd_i && az_q && hit),
      .inc_i     (inc[i]),
      .cnt_o     (cnt_q[i]),
      .wrap_o    (wrap[i])
    );
  end

  stats_carry #(.N(NUM_CNT)) u_carry (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clear_all),
    .w1c_i  (carry_wr),
    .mask_i (reg_wdata_i[NUM_CNT-1:0]),
    .set_i  (wrap),
    .carry_o(carry_q)
  );

  always_comb begin
    reg_rdata_o = '0;
    for (int i = 0; i < NUM_CNT; i++)
      if (reg_addr_i == ADDR_W'(i)) reg_rdata_o = cnt_q[i];
    if (reg_addr_i == ADDR_CARRY) reg_rdata_o = CNT_W'(carry_q);
    if (reg_addr_i == ADDR_CTRL)  reg_rdata_o[CTRL_AZ_BIT] = az_q;
  end
endmodule

// File: rtl/stats_bank_chk.sv
module stats_bank_chk
  import stats_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int ABORT_W = 3
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          stat_valid_i,
  input logic [ABORT_W-1:0]            stat_abort_i,
  input logic                          reg_wr_i,
  input logic                          reg_rd_i,
  input logic [ADDR_W-1:0]             reg_addr_i,
  input logic [CNT_W-1:0]              reg_wdata_i,
  input logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q,
  input logic [NUM_CNT-1:0]            carry_q,
  input logic                          az_q
);
  // R9
  a_r9_clear_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == ADDR_CTRL && reg_wdata_i[CTRL_CLR_BIT])
    |=> (carry_q == '0 && cnt_q == '0));

  // R8: a carry bit only falls after a clear write
  a_r8_carry_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~carry_q & $past(carry_q)) != '0)
    |-> $past(reg_wr_i && (reg_addr_i == ADDR_CARRY || reg_addr_i == ADDR_CTRL)));

  // R3
  a_r3_abort_bins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_valid_i && stat_abort_i != '0 && !reg_wr_i && !reg_rd_i)
    |=> ($stable(cnt_q[NUM_BINS-1:0]) && $stable(cnt_q[IDX_VLAN])));

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_chk
    // R7: a counter that goes down without host access has wrapped
    a_r7_wrap_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!$past(reg_wr_i || reg_rd_i) && (cnt_q[i] < $past(cnt_q[i])))
      |-> carry_q[i]);
    // R10
    a_r10_auto_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_rd_i && !reg_wr_i && !stat_valid_i && az_q && reg_addr_i == ADDR_W'(i))
      |=> (cnt_q[i] == '0));
  end
endmodule

bind stats_bank stats_bank_chk #(.CNT_W(CNT_W), .ABORT_W(ABORT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .stat_valid_i(stat_valid_i),
  .stat_abort_i(stat_abort_i),
  .reg_wr_i    (reg_wr_i),
  .reg_rd_i    (reg_rd_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .cnt_q       (cnt_q),
  .carry_q     (carry_q),
  .az_q        (az_q)
);

// File: tb/tb_stats_bank.sv
`timescale 1ns/1ps
module tb_stats_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stat_valid = 1'b0;
  logic [15:0] stat_len = '0;
  logic        stat_vlan = 1'b0;
  logic        stat_fcs_ok = 1'b0;
  logic [2:0]  stat_abort = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  stats_bank dut (
    .clk_i(clk), .rst_ni(rst_n),
    .stat_valid_i(stat_valid), .stat_len_i(stat_len), .stat_vlan_i(stat_vlan),
    .stat_fcs_ok_i(stat_fcs_ok), .stat_abort_i(stat_abort),
    .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic idle_after_edge();
    @(posedge clk); #1;
    stat_valid = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0;
  endtask

  task automatic frame(input int len, input bit vlan, input bit fcs, input int abrt);
    @(negedge clk);
    stat_valid = 1'b1; stat_len = 16'(len); stat_vlan = vlan;
    stat_fcs_ok = fcs; stat_abort = 3'(abrt);
    idle_after_edge();
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = d;
    idle_after_edge();
  endtask

  task automatic rd_chk(input string tag, input int a, input logic [31:0] exp);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 4'(a);
    #1 check(tag, reg_rdata, exp);
    idle_after_edge();
  endtask

  task automatic t_reset();
    for (int a = 0; a < 11; a++) rd_chk("R1 reset value", a, 32'd0);
  endtask

  task automatic t_bins();
    int lens[9] = '{64, 65, 127, 128, 300, 600, 1023, 1024, 1518};
    int exp_bin[6] = '{1, 2, 1, 1, 2, 2};
    foreach (lens[k]) frame(lens[k], 1'b0, 1'b1, 0);
    for (int b = 0; b < 6; b++) rd_chk("R2 size bin", b, 32'(exp_bin[b]));
    rd_chk("R10 read without auto-zero keeps value", 5, 32'd2);
    rd_chk("R5 byte sum", 7, 32'd4849);
  endtask

  task automatic t_abort();
    wr(10, 32'h1);
    rd_chk("R9 clear-all counter", 7, 32'd0);
    rd_chk("R9 clear-all bin", 1, 32'd0);
    frame(100, 1'b1, 1'b1, 3);
    frame(700, 1'b1, 1'b1, 7);
    rd_chk("R3 aborted frame skips bin", 1, 32'd0);
    rd_chk("R3 aborted frame skips bin", 4, 32'd0);
    rd_chk("R3 aborted frame skips vlan", 6, 32'd0);
    rd_chk("R5 aborted bytes counted", 7, 32'd800);
  endtask

  task automatic t_vlan_over();
    wr(10, 32'h1);
    frame(1519, 1'b0, 1'b1, 0);
    frame(1522, 1'b1, 1'b1, 0);
    frame(1523, 1'b1, 1'b1, 0);
    frame(2000, 1'b0, 1'b0, 0);
    frame(1518, 1'b0, 1'b1, 0);
    frame(1500, 1'b1, 1'b0, 0);
    rd_chk("R6 oversize count", 8, 32'd2);
    rd_chk("R4 good vlan count", 6, 32'd2);
  endtask

  task automatic t_wrap();
    wr(10, 32'h1);
    wr(7, 32'hFFFF_FFF0);
    rd_chk("R11 host load", 7, 32'hFFFF_FFF0);
    frame(32, 1'b0, 1'b1, 0);
    rd_chk("R7 wrapped value", 7, 32'h10);
    rd_chk("R7 carry set", 9, 32'h80);
  endtask

  task automatic t_w1c();
    wr(9, 32'h0);
    rd_chk("R8 zero write keeps carry", 9, 32'h80);
    wr(9, 32'h80);
    rd_chk("R8 one write clears carry", 9, 32'h0);
    wr(0, 32'hFFFF_FFFF);
    @(negedge clk);
    stat_valid = 1'b1; stat_len = 16'd64; stat_vlan = 1'b0;
    stat_fcs_ok = 1'b1; stat_abort = '0;
    reg_wr = 1'b1; reg_addr = 4'd9; reg_wdata = 32'h1;
    idle_after_edge();
    rd_chk("R8 wrap beats clear", 9, 32'h1);
    rd_chk("R7 bin wrapped", 0, 32'h0);
  endtask

  task automatic t_clear_all();
    @(negedge clk);
    stat_valid = 1'b1; stat_len = 16'd64; stat_vlan = 1'b0;
    stat_fcs_ok = 1'b1; stat_abort = '0;
    reg_wr = 1'b1; reg_addr = 4'd10; reg_wdata = 32'h1;
    idle_after_edge();
    rd_chk("R9 clear beats update bin", 0, 32'h0);
    rd_chk("R9 clear beats update bytes", 7, 32'h0);
    rd_chk("R9 carry cleared", 9, 32'h0);
    rd_chk("R9 clear bit reads zero", 10, 32'h0);
  endtask

  task automatic t_auto_zero();
    wr(10, 32'h2);
    rd_chk("R10 mode bit", 10, 32'h2);
    repeat (3) frame(1100, 1'b0, 1'b1, 0);
    rd_chk("R10 read returns count", 5, 32'd3);
    rd_chk("R10 read zeroed counter", 5, 32'd0);
    @(negedge clk);
    stat_valid = 1'b1; stat_len = 16'd200; stat_vlan = 1'b0;
    stat_fcs_ok = 1'b1; stat_abort = '0;
    reg_rd = 1'b1; reg_addr = 4'd7;
    #1 check("R10 read with update returns old", reg_rdata, 32'd3300);
    idle_after_edge();
    rd_chk("R10 only new increment kept", 7, 32'd200);
    wr(3, 32'd77);
    frame(300, 1'b0, 1'b1, 0);
    rd_chk("R11 load then increment", 3, 32'd78);
    wr(10, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_bins();
    t_abort();
    t_vlan_over();
    t_wrap();
    t_w1c();
    t_clear_all();
    t_auto_zero();
    repeat (2) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule